// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block sits beside a processor core and decides when the core leaves normal execution for background debug mode. It watches three kinds of event: a double bus fault (a run of bus faults with no good bus cycle between them), a strobe from the decoder saying a background instruction was decoded, and a breakpoint request line. External logic and on-chip peripherals share that breakpoint line.

When debug is allowed and one of these events arrives, the block raises a freeze output. Freeze stops instruction issue and is the first visible sign of debug mode. In the same clock edge the block loads a 32-bit cause code into a temporary debug register, which a debugger reads back as its first action.

When debug is not allowed, a double bus fault halts the core instead. If the double fault happens during the reset stack-pointer/program-counter fetch, the block also tells the core to force its program counter to all ones. That odd value marks the failed reset fetch, and no other path produces it. A return-from-debug strobe releases freeze or halt.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After a synchronous reset, `freeze`, `halt` and `pc_force` are 0, and `cause_code` and `pc_value` are all zeros.
- R2: `FAULT_LIMIT` `bus_fault` strobes form a double bus fault when no `bus_ok` strobe comes between them. Idle cycles between the strobes do not break the run. A `bus_ok` strobe without `bus_fault` in the same cycle clears the run.
- R3: On a double bus fault with `dbg_en`=1, `freeze` is 1 after the next clock edge. `cause_code` then holds `ssw` in bits 31:16 and 0xFFFF in bits 15:0.
- R4: On a double bus fault with `dbg_en`=0, `halt` is 1 after the next clock edge. `freeze` stays 0 and `cause_code` keeps its old value.
- R5: A `bgnd_dec` strobe with `dbg_en`=1 sets `freeze` after the next edge and loads `cause_code` with 0x0000_0001.
- R6: A `brk_req` with `dbg_en`=1 sets `freeze` after the next edge and loads `cause_code` with 0x0000_0000.
- R7: When several causes occur in one cycle, the cause code is chosen in this order: double bus fault first, then background instruction, then breakpoint.
- R8: With `dbg_en`=0, `bgnd_dec` and `brk_req` have no effect on any output.
- R9: A double bus fault while `reset_fetch`=1 drives `pc_force` to 1 for exactly one cycle, with `pc_value` all ones. This holds whatever `dbg_en` is. At every other time `pc_value` is all zeros, so it is never odd.
- R10: While `freeze` or `halt` is 1, all event inputs are ignored and `cause_code` holds. The consecutive-fault run is discarded, so a single fault after resuming does not complete a double fault.
- R11: A `resume` strobe while `freeze` or `halt` is 1 clears both after the next edge. `freeze` and `halt` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_fault | input | 1 | One-cycle strobe: a bus cycle ended in a fault |
| bus_ok | input | 1 | One-cycle strobe: a bus cycle ended normally |
| bgnd_dec | input | 1 | Background instruction decoded |
| brk_req | input | 1 | Breakpoint request, external or peripheral |
| dbg_en | input | 1 | Debug mode allowed (strap) |
| ssw | input | SSW_W | Special status word of the faulting access |
| reset_fetch | input | 1 | Core is in the reset SP/PC fetch phase |
| resume | input | 1 | Return-from-debug strobe |
| freeze | output | 1 | Debug mode active; instruction issue stopped |
| halt | output | 1 | Core halted on an unrecoverable double fault |
| cause_code | output | CODE_W | Temporary debug register holding the entry cause |
| pc_force | output | 1 | One-cycle request to overwrite the program counter |
| pc_value | output | PC_W | Value to load into the program counter when forced |

## Verification
The bench builds the block with its default parameters: a 32-bit cause code, a 16-bit status word, a 32-bit program counter and a fault limit of two. With the limit at two, one prepared fault followed by one stimulus cycle reaches every combination of double fault, background strobe, breakpoint, debug enable and reset-fetch phase. All 32 of these combinations are swept, and the expected freeze, halt, cause code and PC override are computed from the priority rules. Directed sequences then cover a run broken by a good bus cycle, idle gaps inside a run, and events arriving while the block is frozen.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

  // Source of a debug-mode entry, in decreasing priority order after NONE
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DBLF = 2'd1,
    SRC_BGND = 2'd2,
    SRC_BRKP = 2'd3
  } entry_src_e;

endpackage

// File: rtl/dbg_fault_run.sv
// Counts bus faults that arrive with no good bus cycle between them and
// reports when the run reaches the configured limit.
module dbg_fault_run #(
  parameter int FAULT_LIMIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bus_fault,
  input  logic bus_ok,
  output logic dbl_fault
);

  localparam int CNT_W = $clog2(FAULT_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FAULT_LIMIT - 1);

  logic [CNT_W-1:0] run_cnt;

  assign dbl_fault = en && bus_fault && (run_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run_cnt <= '0;
    end else if (bus_fault) begin
      if (run_cnt == LAST) run_cnt <= '0;
      else                 run_cnt <= run_cnt + 1'b1;
    end else if (bus_ok) begin
      run_cnt <= '0;
    end
  end

endmodule

// File: rtl/dbg_cause_sel.sv
// Picks the winning entry cause and forms its code.
module dbg_cause_sel
  import dbg_entry_pkg::*;
#(
  parameter int CODE_W = 32,
  parameter int SSW_W  = 16
) (
  input  logic              dbl,
  input  logic              bgnd,
  input  logic              brk,
  input  logic              dbg_en,
  input  logic [SSW_W-1:0]  ssw,
  output logic              go_dbg,
  output logic              go_halt,
  output logic [CODE_W-1:0] code
);

  localparam int LOW_W = CODE_W - SSW_W;

  entry_src_e src;

  always_comb begin
    src = SRC_NONE;
    if (dbl)                src = SRC_DBLF;
    else if (bgnd && dbg_en) src = SRC_BGND;
    else if (brk && dbg_en)  src = SRC_BRKP;
  end

  always_comb begin
    case (src)
      SRC_DBLF: code = {ssw, {LOW_W{1'b1}}};
      SRC_BGND: code = CODE_W'(1);
      default:  code = '0;
    endcase
  end

  assign go_dbg  = (src != SRC_NONE) && dbg_en;
  assign go_halt = (src == SRC_DBLF) && !dbg_en;

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl #(
  parameter int CODE_W      = 32,
  parameter int SSW_W       = 16,
  parameter int PC_W        = 32,
  parameter int FAULT_LIMIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_fault,
  input  logic              bus_ok,
  input  logic              bgnd_dec,
  input  logic              brk_req,
  input  logic              dbg_en,
  input  logic [SSW_W-1:0]  ssw,
  input  logic              reset_fetch,
  input  logic              resume,
  output logic              freeze,
  output logic              halt,
  output logic [CODE_W-1:0] cause_code,
  output logic              pc_force,
  output logic [PC_W-1:0]   pc_value
);

  logic              active;
  logic              dbl;
  logic              go_dbg;
  logic              go_halt;
  logic [CODE_W-1:0] new_code;

  assign active = !(freeze || halt);

  dbg_fault_run #(
    .FAULT_LIMIT(FAULT_LIMIT)
  ) u_run (
    .clk      (clk),
    .rst      (rst),
    .en       (active),
    .bus_fault(bus_fault),
    .bus_ok   (bus_ok),
    .dbl_fault(dbl)
  );

  dbg_cause_sel #(
    .CODE_W(CODE_W),
    .SSW_W (SSW_W)
  ) u_sel (
    .dbl    (dbl),
    .bgnd   (bgnd_dec && active),
    .brk    (brk_req && active),
    .dbg_en (dbg_en),
    .ssw    (ssw),
    .go_dbg (go_dbg),
    .go_halt(go_halt),
    .code   (new_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      freeze     <= 1'b0;
      halt       <= 1'b0;
      cause_code <= '0;
      pc_force   <= 1'b0;
      pc_value   <= '0;
    end else begin
      pc_force <= 1'b0;
      pc_value <= '0;
      if (!active) begin
        if (resume) begin
          freeze <= 1'b0;
          halt   <= 1'b0;
        end
      end else begin
        if (go_dbg) begin
          freeze     <= 1'b1;
          cause_code <= new_code;
        end
        if (go_halt) halt <= 1'b1;
        if (dbl && reset_fetch) begin
          pc_force <= 1'b1;
          pc_value <= '1;
        end
      end
    end
  end

endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk #(
  parameter int CODE_W = 32,
  parameter int SSW_W  = 16,
  parameter int PC_W   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_fault,
  input logic              bgnd_dec,
  input logic              dbg_en,
  input logic              reset_fetch,
  input logic              resume,
  input logic              freeze,
  input logic              halt,
  input logic [CODE_W-1:0] cause_code,
  input logic              pc_force,
  input logic [PC_W-1:0]   pc_value
);

  AST_FRZ_HALT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(freeze && halt)); // R11

  AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (freeze || halt) && resume |=> !freeze && !halt); // R11

  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (rst)
    $past(freeze) && freeze |-> $stable(cause_code)); // R10

  AST_HALT_ONLY_DISABLED: assert property (@(posedge clk) disable iff (rst)
    $rose(halt) |-> !$past(dbg_en) && $past(bus_fault)); // R4

  AST_BGND_CODE: assert property (@(posedge clk) disable iff (rst)
    $rose(freeze) && !$past(bus_fault) && $past(bgnd_dec) |-> cause_code == CODE_W'(1)); // R5

  AST_PC_FORCE_SRC: assert property (@(posedge clk) disable iff (rst)
    pc_force |-> $past(reset_fetch) && $past(bus_fault) && (&pc_value)); // R9

  AST_PC_NEVER_ODD: assert property (@(posedge clk) disable iff (rst)
    !pc_force |-> pc_value == '0); // R9

  AST_FORCE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pc_force |=> !pc_force); // R9

endmodule

bind dbg_entry_ctrl dbg_entry_chk #(
  .CODE_W(CODE_W),
  .SSW_W (SSW_W),
  .PC_W  (PC_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_fault  (bus_fault),
  .bgnd_dec   (bgnd_dec),
  .dbg_en     (dbg_en),
  .reset_fetch(reset_fetch),
  .resume     (resume),
  .freeze     (freeze),
  .halt       (halt),
  .cause_code (cause_code),
  .pc_force   (pc_force),
  .pc_value   (pc_value)
);

// File: tb/dbg_entry_ctrl_test.sv
`timescale 1ns/1ps
module dbg_entry_ctrl_test;

  localparam int CLK_P = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_fault = 0, bus_ok = 0, bgnd_dec = 0, brk_req = 0;
  logic        dbg_en = 0, reset_fetch = 0, resume = 0;
  logic [15:0] ssw = '0;
  logic        freeze, halt, pc_force;
  logic [31:0] cause_code, pc_value;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_P / 2.0) clk = ~clk;

  dbg_entry_ctrl uut (
    .clk(clk), .rst(rst), .bus_fault(bus_fault), .bus_ok(bus_ok),
    .bgnd_dec(bgnd_dec), .brk_req(brk_req), .dbg_en(dbg_en), .ssw(ssw),
    .reset_fetch(reset_fetch), .resume(resume), .freeze(freeze), .halt(halt),
    .cause_code(cause_code), .pc_force(pc_force), .pc_value(pc_value)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // inputs change 1 ns after an edge; outputs are sampled there too
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_in();
    bus_fault = 0; bus_ok = 0; bgnd_dec = 0; brk_req = 0;
    reset_fetch = 0; resume = 0;
  endtask

  task automatic do_reset();
    idle_in();
    rst = 1;
    step(); step();
    rst = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step();
    do_reset();
    chk("R1 freeze", {31'b0, freeze}, 32'd0);
    chk("R1 halt", {31'b0, halt}, 32'd0);
    chk("R1 pc_force", {31'b0, pc_force}, 32'd0);
    chk("R1 cause", cause_code, 32'd0);
    chk("R1 pc_value", pc_value, 32'd0);

    // Sweep: double fault x bgnd x brk x dbg_en x reset_fetch (R3 R4 R5 R6 R7 R8 R9)
    for (int i = 0; i < 32; i++) begin
      logic d, b, k, e, rf;
      logic [15:0] s;
      logic [31:0] exp_code;
      d = i[0]; b = i[1]; k = i[2]; e = i[3]; rf = i[4];
      s = 16'hA5C0 ^ 16'(i * 16'h0111);
      do_reset();
      dbg_en = e;
      if (d) begin
        bus_fault = 1;
        step();
        chk("R2 single fault no entry", {30'b0, freeze, halt}, 32'd0);
      end
      bus_fault = d; bgnd_dec = b; brk_req = k; reset_fetch = rf; ssw = s;
      step();
      idle_in();
      exp_code = (e && d) ? {s, 16'hFFFF} : (e && b) ? 32'd1 : 32'd0;
      chk("R3/R5/R6/R8 freeze", {31'b0, freeze}, {31'b0, e && (d || b || k)});
      chk("R4 halt", {31'b0, halt}, {31'b0, d && !e});
      chk("R7 cause code", cause_code, exp_code);
      chk("R9 pc_force", {31'b0, pc_force}, {31'b0, d && rf});
      chk("R9 pc_value", pc_value, (d && rf) ? 32'hFFFF_FFFF : 32'd0);
      step();
      chk("R9 force one cycle", {31'b0, pc_force}, 32'd0);
      chk("R10 cause held", cause_code, exp_code);
      resume = 1;
      step();
      resume = 0;
      chk("R11 resume clears", {30'b0, freeze, halt}, 32'd0);
    end

    // R2: good cycle breaks the run
    do_reset();
    dbg_en = 1;
    bus_fault = 1; step(); idle_in();
    bus_ok = 1;    step(); idle_in();
    bus_fault = 1; step(); idle_in();
    chk("R2 broken run no freeze", {31'b0, freeze}, 32'd0);
    step(); step();
    bus_fault = 1; ssw = 16'h1234; step(); idle_in();
    chk("R2 idle gap keeps run", {31'b0, freeze}, 32'd1);
    chk("R2 cause after gap", cause_code, 32'h1234_FFFF);

    // R10: events while frozen are ignored; run discarded
    do_reset();
    dbg_en = 1;
    bus_fault = 1; step(); idle_in();
    brk_req = 1;   step(); idle_in();
    chk("R6 brk entry", {31'b0, freeze}, 32'd1);
    bgnd_dec = 1; bus_fault = 1; reset_fetch = 1; step(); idle_in();
    bus_fault = 1; step(); idle_in();
    chk("R10 cause held frozen", cause_code, 32'd0);
    chk("R10 no halt frozen", {31'b0, halt}, 32'd0);
    chk("R10 no pc_force frozen", {31'b0, pc_force}, 32'd0);
    resume = 1; step(); idle_in();
    chk("R11 resume", {31'b0, freeze}, 32'd0);
    bus_fault = 1; step(); idle_in();
    chk("R10 run discarded", {31'b0, freeze}, 32'd0);

    // R10/R11: halted core ignores debug events until resume
    do_reset();
    dbg_en = 0;
    bus_fault = 1; step();
    step(); idle_in();
    chk("R4 halted", {31'b0, halt}, 32'd1);
    dbg_en = 1; bgnd_dec = 1; step(); idle_in();
    chk("R10 halted ignores bgnd", {30'b0, freeze, halt}, 32'd1);
    chk("R4 cause untouched", cause_code, 32'd0);
    resume = 1; step(); idle_in();
    chk("R11 halt cleared", {30'b0, freeze, halt}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule